// File: doc/BRIEF.md
# Interlocked Nonvolatile Write Controller

This block controls writes into a small on-chip nonvolatile data array. A CPU loads three registers through a simple register-write port: an address register, a data register and a control register. A write starts only after a two-step arming handshake. First, one control write sets an arm flag. Then a second control write, issued within a short window, fires the strobe. When the strobe is accepted, the block captures the address and data registers. It then holds the array write-enable high with those captured values for a fixed number of cycles, and reports itself busy for that time.

The interlock rejects several kinds of strobe:
- a strobe that arrives after the arm window has closed;
- a strobe issued while a self-programming operation elsewhere on the chip is running;
- a strobe issued while an earlier write is still running.

A reset that lands in the middle of a write does not cut the array write short. It only forces the address register, and the other software-visible registers, back to zero.

Top module: `nvw_ctrl`

## Requirements
- R1: After an arming write, a strobe write is accepted only if it comes at one of the next ARM_WINDOW (default 4) rising edges. A later strobe leaves busy low and raises no array write-enable.
- R2: The arm flag reads back on ctrl_rd[0]. A control write (reg_sel 2) with bit 0 = 1 and bit 1 = 0 sets it. A control write with both bits 0 clears it. Any strobe write (bit 1 = 1) while idle consumes it. A write with both bits set does not arm.
- R3: ctrl_rd[1] reads 1 from the edge that accepts a strobe for exactly PROG_CYCLES (default 16) cycles, then returns to 0.
- R4: mem_we is high for exactly PROG_CYCLES cycles per accepted strobe. During that time mem_addr and mem_wdata equal the address and data register contents at the accepting edge, and do not change.
- R5: A strobe presented while spm_busy is high starts no write and consumes the arm flag.
- R6: With rst_n low at an edge, the address register, the data register and the arm flag become zero. A write already running continues to completion with unchanged mem_addr and mem_wdata.
- R7: The address register (reg_sel 0) and data register (reg_sel 1) can be loaded in either order, or not reloaded at all. Reloading them during a write does not alter mem_addr or mem_wdata. reg_sel 3 has no effect.
- R8: While busy, a control write has one effect only: a write with bit 0 = 0 clears the arm flag. Arm-setting writes and strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 data, 2 control, 3 none |
| reg_wdata | input | BUS_W | Register write data |
| spm_busy | input | 1 | Self-programming operation active |
| addr_rd | output | AW | Address register contents |
| data_rd | output | DW | Data register contents |
| ctrl_rd | output | 2 | Control readback: bit 0 arm flag, bit 1 write running |
| mem_addr | output | AW | Array address, captured at write start |
| mem_wdata | output | DW | Array data, captured at write start |
| mem_we | output | 1 | Array write-enable, high for the programming time |

## Verification
The bench runs a reference model cycle by cycle and uses several strobe patterns to test the window boundaries:
- A strobe at the first edge after arming and a strobe at the fourth edge must both start a write.
- A strobe at the fifth edge must not start one; this separates a correct window from an off-by-one window.
- A combined arm-and-strobe write must not start a write, which shows that the arm step cannot be skipped.
- A strobe while spm_busy is high must be refused.
- A strobe after an explicit disarm must be refused.

Reloading the registers during a write, and asserting reset mid-write, show whether the array values were captured at the start of the write. They also show whether the programming timer survives a reset.

// File: rtl/nvw_pkg.sv
// Package nvw_pkg: register select codes and control bit positions
// shared by the nonvolatile write controller and its sub-blocks.
package nvw_pkg;
    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } nvw_sel_e;

    localparam int CTRL_ARM_BIT = 0;
    localparam int CTRL_STB_BIT = 1;
endpackage

// File: rtl/nvw_regs.sv
// nvw_regs: software-visible address and data registers.
// Assumes: reset is synchronous active-low; sel is a plain 2-bit code.
module nvw_regs #(
    parameter int AW    = 9,
    parameter int DW    = 8,
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       sel,
    input  logic [BUS_W-1:0] wdata,
    output logic [AW-1:0]    addr_q,
    output logic [DW-1:0]    data_q
);
    import nvw_pkg::*;

    // Load whichever register is selected; reset clears both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (we && (sel == SEL_ADDR)) begin
            addr_q <= wdata[AW-1:0];
        end else if (we && (sel == SEL_DATA)) begin
            data_q <= wdata[DW-1:0];
        end
    end

    AST_ADDR_RST: assert property (@(posedge clk) !rst_n |=> (addr_q == '0)); // R6
endmodule

// File: rtl/nvw_arm.sv
// nvw_arm: arm flag with a closing window.
// Assumes: busy is the registered write-running flag of the engine.
// The flag stays valid for WIN rising edges after the arming edge.
module nvw_arm #(
    parameter int WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic wr_arm,
    input  logic wr_stb,
    input  logic busy,
    output logic arm_q
);
    localparam int LW = $clog2(WIN + 1);

    logic [LW-1:0] left_q;
    logic          arm_set;
    logic          arm_kill;

    // Decode which control writes arm and which disarm.
    always_comb begin
        arm_set  = ctrl_wr && !busy && !wr_stb && wr_arm;
        arm_kill = ctrl_wr && (busy ? !wr_arm : (wr_stb || !wr_arm));
    end

    // Count remaining window edges.
    always_ff @(posedge clk) begin
        if (!rst_n)            left_q <= '0;
        else if (arm_set)      left_q <= LW'(WIN);
        else if (arm_kill)     left_q <= '0;
        else if (left_q != '0) left_q <= left_q - 1'b1;
    end

    assign arm_q = (left_q != '0);

    // Independent age counter, used only by the window check.
    logic [LW:0] age_q;
    always_ff @(posedge clk) begin
        if (arm_set || !arm_q) age_q <= '0;
        else                   age_q <= age_q + 1'b1;
    end

    AST_ARM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        arm_q |-> (age_q < (LW+1)'(WIN))); // R1
endmodule

// File: rtl/nvw_prog.sv
// nvw_prog: programming engine. On start it captures address and data
// and holds them with busy high for PROG_CYCLES cycles. A reset does not
// stop a running operation; the engine is cleared only when idle.
module nvw_prog #(
    parameter int AW          = 9,
    parameter int DW          = 8,
    parameter int PROG_CYCLES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output logic          busy_q,
    output logic [AW-1:0] lat_addr,
    output logic [DW-1:0] lat_data
);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [CW-1:0] left_q;

    // Run the timer; start captures operands; reset clears only when idle.
    always_ff @(posedge clk) begin
        if (busy_q) begin
            if (left_q == CW'(1)) busy_q <= 1'b0;
            left_q <= left_q - 1'b1;
        end else if (start) begin
            busy_q   <= 1'b1;
            left_q   <= CW'(PROG_CYCLES);
            lat_addr <= addr_in;
            lat_data <= data_in;
        end else if (!rst_n) begin
            busy_q   <= 1'b0;
            left_q   <= '0;
            lat_addr <= '0;
            lat_data <= '0;
        end
    end

    // Independent run-length counter for the duration check.
    logic [CW:0] run_q;
    always_ff @(posedge clk) begin
        if (!busy_q) run_q <= '0;
        else         run_q <= run_q + 1'b1;
    end

    AST_RUN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (run_q < (CW+1)'(PROG_CYCLES))); // R3
    AST_RUN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> ($past(run_q) == (CW+1)'(PROG_CYCLES - 1))); // R4
endmodule

// File: rtl/nvw_ctrl.sv
// nvw_ctrl: interlocked write controller for an on-chip nonvolatile array.
// Assumes: one register write per cycle; spm_busy is synchronous to clk.
module nvw_ctrl #(
    parameter int AW          = 9,
    parameter int DW          = 8,
    parameter int BUS_W       = 16,
    parameter int ARM_WINDOW  = 4,
    parameter int PROG_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_sel,
    input  logic [BUS_W-1:0] reg_wdata,
    input  logic             spm_busy,
    output logic [AW-1:0]    addr_rd,
    output logic [DW-1:0]    data_rd,
    output logic [1:0]       ctrl_rd,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic             mem_we
);
    import nvw_pkg::*;

    logic ctrl_wr, wr_arm, wr_stb, arm_q, busy, start;

    // Decode control-register writes and the write-start condition.
    always_comb begin
        ctrl_wr = reg_we && (reg_sel == SEL_CTRL) && rst_n;
        wr_arm  = reg_wdata[CTRL_ARM_BIT];
        wr_stb  = reg_wdata[CTRL_STB_BIT];
        start   = ctrl_wr && wr_stb && arm_q && !busy && !spm_busy;
    end

    nvw_regs #(.AW(AW), .DW(DW), .BUS_W(BUS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel),
        .wdata(reg_wdata), .addr_q(addr_rd), .data_q(data_rd)
    );

    nvw_arm #(.WIN(ARM_WINDOW)) u_arm (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wr_arm(wr_arm),
        .wr_stb(wr_stb), .busy(busy), .arm_q(arm_q)
    );

    nvw_prog #(.AW(AW), .DW(DW), .PROG_CYCLES(PROG_CYCLES)) u_prog (
        .clk(clk), .rst_n(rst_n), .start(start), .addr_in(addr_rd),
        .data_in(data_rd), .busy_q(busy), .lat_addr(mem_addr),
        .lat_data(mem_wdata)
    );

    assign ctrl_rd = {busy, arm_q};
    assign mem_we  = busy;

    AST_START_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(arm_q)); // R1
    AST_NO_START_SPM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(spm_busy)); // R5
    AST_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(mem_addr) && $stable(mem_wdata))); // R4
    AST_NO_ARM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !arm_q) |=> !arm_q); // R8
endmodule

// File: tb/tb_nvw_ctrl.sv
module tb_nvw_ctrl;
    localparam int AW = 9, DW = 8, BW = 16, WIN = 4, PROG = 16;

    logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, spm = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [BW-1:0] reg_wdata = '0;
    logic [AW-1:0] addr_rd, mem_addr;
    logic [DW-1:0] data_rd, mem_wdata;
    logic [1:0] ctrl_rd;
    logic mem_we;

    int checks = 0, errors = 0, cycles = 0;
    bit started = 0;

    // reference model state
    int m_addr = 0, m_data = 0, m_arm = 0, m_busy = 0, m_la = 0, m_ld = 0;

    nvw_ctrl #(.AW(AW), .DW(DW), .BUS_W(BW), .ARM_WINDOW(WIN), .PROG_CYCLES(PROG)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .spm_busy(spm), .addr_rd(addr_rd),
        .data_rd(data_rd), .ctrl_rd(ctrl_rd), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we)
    );

    always #10 clk = ~clk;

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model, advanced on every rising edge.
    always @(posedge clk) begin
        bit ctl, go;
        int busy_before;
        started = 1;
        cycles++;
        ctl = rst_n && reg_we && (reg_sel == 2'd2);
        busy_before = m_busy;
        go = ctl && reg_wdata[1] && (m_arm > 0) && (m_busy == 0) && !spm;
        if (m_busy > 0) m_busy--;
        else if (go) begin m_busy = PROG; m_la = m_addr; m_ld = m_data; end
        else if (!rst_n) begin m_la = 0; m_ld = 0; end
        if (!rst_n) m_arm = 0;
        else if (ctl && busy_before > 0) m_arm = reg_wdata[0] ? (m_arm > 0 ? m_arm - 1 : 0) : 0;
        else if (ctl) m_arm = reg_wdata[1] ? 0 : (reg_wdata[0] ? WIN : 0);
        else if (m_arm > 0) m_arm--;
        if (!rst_n) begin m_addr = 0; m_data = 0; end
        else if (reg_we && reg_sel == 2'd0) m_addr = int'(reg_wdata[AW-1:0]);
        else if (reg_we && reg_sel == 2'd1) m_data = int'(reg_wdata[DW-1:0]);
        if (cycles > 20000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<20000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Compare every output against the model away from the edge.
    always @(negedge clk) if (started) begin
        chk(addr_rd, m_addr, "R7 addr");
        chk(data_rd, m_data, "R7 data");
        chk(ctrl_rd[0], m_arm > 0, "R2 arm");
        chk(ctrl_rd[1], m_busy > 0, "R3 busy");
        chk(mem_we, m_busy > 0, "R4 we");
        if (m_busy > 0) begin
            chk(mem_addr, m_la, "R4 maddr");
            chk(mem_wdata, m_ld, "R4 mdata");
        end
    end

    task automatic step(input logic we, input logic [1:0] s, input int d);
        reg_we = we; reg_sel = s; reg_wdata = BW'(d);
        @(posedge clk); #2;
        reg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 2'd0, 0);
    endtask

    initial begin
        idle(2);
        chk(addr_rd, 0, "R6 reset addr");
        chk(ctrl_rd, 0, "R6 reset ctrl");
        rst_n = 1'b1;
        idle(1);
        // write at first edge of window
        step(1, 2'd0, 'h1A3); step(1, 2'd1, 'h5C);
        step(1, 2'd2, 1); step(1, 2'd2, 2);
        chk(mem_we, 1, "R1 strobe at edge 1");
        chk(mem_addr, 'h1A3, "R4 addr captured");
        // reload and control writes during the write
        step(1, 2'd1, 'h77); step(1, 2'd0, 'h0F0);
        step(1, 2'd2, 1); step(1, 2'd2, 2);
        chk(ctrl_rd[0], 0, "R8 arm ignored while busy");
        chk(mem_wdata, 'h5C, "R7 data held");
        step(1, 2'd3, 'hFFFF);
        idle(PROG);
        chk(mem_we, 0, "R3 write ended");
        // strobe at the last edge of the window
        step(1, 2'd2, 1); idle(WIN - 1); step(1, 2'd2, 2);
        chk(mem_we, 1, "R1 strobe at last window edge");
        chk(mem_wdata, 'h77, "R7 reused data");
        idle(PROG + 1);
        // strobe one edge too late
        step(1, 2'd2, 1); idle(WIN); step(1, 2'd2, 2);
        chk(mem_we, 0, "R1 expired strobe");
        // combined arm and strobe
        step(1, 2'd2, 3); step(1, 2'd2, 2);
        chk(mem_we, 0, "R2 combined write does not arm");
        // explicit disarm
        step(1, 2'd2, 1); step(1, 2'd2, 0);
        chk(ctrl_rd[0], 0, "R2 disarm");
        step(1, 2'd2, 2);
        chk(mem_we, 0, "R2 strobe after disarm");
        // self-programming interlock
        spm = 1'b1;
        step(1, 2'd2, 1); step(1, 2'd2, 2);
        chk(mem_we, 0, "R5 strobe blocked");
        chk(ctrl_rd[0], 0, "R5 arm consumed");
        spm = 1'b0;
        idle(2);
        // data first, then address; reset during the write
        step(1, 2'd1, 'hA5); step(1, 2'd0, 'h155);
        step(1, 2'd2, 1); idle(1); step(1, 2'd2, 2);
        idle(3);
        rst_n = 1'b0;
        idle(2);
        chk(mem_we, 1, "R6 write survives reset");
        chk(addr_rd, 0, "R6 addr cleared");
        chk(mem_addr, 'h155, "R6 captured addr kept");
        rst_n = 1'b1;
        // disarm during busy via bit0=0
        step(1, 2'd2, 0);
        idle(PROG);
        chk(mem_we, 0, "R3 write finished after reset");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule